// File: doc/BRIEF.md
# Banked SRAM Interface With Wait States

This block connects an internal request port to an external 16-bit asynchronous static memory. The memory space is split into four banks, each with its own active-low chip select. Which select fires depends on the page of the address, that is, its upper six bits. Those bits are compared against four programmable boundary values. Every access has three phases: an address setup cycle, a strobe phase and an address hold cycle. The strobe phase can be stretched by a programmable number of wait states so that slow parts can be used.

An external master can take the memory bus with an active-low bus-request line. The block first finishes the access it has already started. It then stops driving addresses, data, selects and strobes, and it holds back any new work until the request is withdrawn. Two start inputs launch block transfers of consecutive words from a programmable base address. A rising edge on one start input reads a block out of memory onto the response port. A rising edge on the other writes a block into memory from a word source. Each direction has a ready flag that reports when its block is complete.

All outputs are registered. The floating itself is done by pads outside the block, under control of two output-enable signals.

Top module: `bank_sram_ctrl`

## Requirements
- R1: The block has 16-bit address and data buses and four active-low chip selects. At most one chip select is low in any cycle.
- R2: Bank selection is done per access. Address bits [15:10] are compared against bits [5:0] of each 8-bit boundary field. Field i is bank_bound[8i+7:8i], and bits [7:6] of each field are ignored. The lowest bank i whose boundary is greater than the page is selected. If no boundary is greater than the page, bank 3 is selected. Chip select i is mem_cs_n[i].
- R3: The chip select and the read or write strobe stay low for exactly ws_cfg+1 cycles. The value of ws_cfg ranges from 0 to 7.
- R4: The address is driven one cycle before the chip select falls and is held for one cycle after it rises. mem_data_oe is high whenever the write strobe is low.
- R5: For a read, the data on mem_din in the last strobe cycle is returned on rsp_rdata. rsp_valid is high for one cycle, in the cycle after the strobe rises.
- R6: While bus_req_n is low, the access in progress completes. The cycle after the block sees the request while idle, mem_bus_oe goes low. req_ready stays low and no access starts until bus_req_n returns high. mem_bus_oe goes high one cycle after the release. A bus request takes priority over block transfers and single requests.
- R7: A rising edge on start_tx reads blk_len+1 words starting at blk_base. The address increments by one per word and wraps from 0xFFFF to 0x0000. Each word appears on the response port. tx_ready rises after the last word and falls again on the next rising edge of start_tx.
- R8: A rising edge on start_rx writes blk_len+1 words into memory starting at blk_base, in the same address order as R7. Each word comes from rx_wdata, and rx_take pulses once for each word taken. rx_ready rises after the last write and falls again on the next rising edge of start_rx.
- R9: After reset, the following hold: chip selects and strobes are high, mem_bus_oe=1, mem_data_oe=0, both ready flags are 0, rsp_valid=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_cfg | input | 3 | Wait states per access |
| bank_bound | input | 32 | Four 8-bit bank boundary fields |
| blk_base | input | 16 | First address of a block transfer |
| blk_len | input | 8 | Words in a block, minus one |
| req_valid | input | 1 | Single request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Request write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Memory write data |
| mem_din | input | 16 | Memory read data |
| mem_data_oe | output | 1 | Drive the data bus |
| mem_bus_oe | output | 1 | Drive address, selects and strobes |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe |
| bus_req_n | input | 1 | Active-low external bus request |
| start_tx | input | 1 | Rising edge starts a block read |
| tx_ready | output | 1 | Block read complete |
| start_rx | input | 1 | Rising edge starts a block write |
| rx_wdata | input | 16 | Word source for block writes |
| rx_take | output | 1 | One-cycle pulse per word taken |
| rx_ready | output | 1 | Block write complete |

## Verification
The hardest situation to reach from the ports is a bus request that arrives while a write is already under way, followed by a single request that is waiting while the bus is surrendered. The bench issues a write with three wait states and pulls bus_req_n low one cycle after the write is accepted. It then checks three things: the written word is in the memory model, the outputs have floated, and the pending read neither starts nor is accepted. Finally it releases the bus and checks that the read returns the surrendered write's data. The bench also checks two address corner cases. A block read crosses a page boundary, so the chip select changes in the middle of the block. A block write wraps from the top of the address space to zero.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_YIELD
  } sram_st_t;
endpackage

// File: rtl/bank_sel.sv
// Page-to-bank decoder: lowest bank whose boundary exceeds the page wins.
module bank_sel #(
  parameter int NBANK = 4,
  parameter int BND_W = 8,
  parameter int PG_W  = 6,
  localparam int BK_W = $clog2(NBANK)
) (
  input  logic [PG_W-1:0]        page,
  input  logic [NBANK*BND_W-1:0] bounds,
  output logic [BK_W-1:0]        bank
);
  logic [NBANK-1:0] hit;
  logic [NBANK-1:0] unused_hi;

  for (genvar i = 0; i < NBANK; i++) begin : g_cmp
    assign hit[i]       = page < bounds[i*BND_W +: PG_W];
    assign unused_hi[i] = ^bounds[i*BND_W+PG_W +: BND_W-PG_W];
  end

  always_comb begin
    bank = BK_W'(NBANK-1);
    for (int i = NBANK-1; i >= 0; i--) begin
      if (hit[i]) bank = BK_W'(i);
    end
  end
endmodule

// File: rtl/start_detect.sv
// Rising-edge detector with a pending flag held until consumed.
module start_detect (
  input  logic clk,
  input  logic rst,
  input  logic start_in,
  input  logic consume,
  output logic rise,
  output logic pending
);
  logic prev_q;

  assign rise = start_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev_q <= start_in;
      if (rise)         pending <= 1'b1;
      else if (consume) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_timer.sv
// Down-counter setting the strobe length: load ws, done when it reaches zero.
module strobe_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WS_W-1:0] val,
  output logic            done
);
  logic [WS_W-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/bank_sram_ctrl.sv
module bank_sram_ctrl
  import sram_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NBANK     = 4,
  parameter int BND_W     = 8,
  parameter int PAGE_LOG2 = 10,
  parameter int WS_W      = 3,
  parameter int LEN_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WS_W-1:0]        ws_cfg,
  input  logic [NBANK*BND_W-1:0] bank_bound,
  input  logic [ADDR_W-1:0]      blk_base,
  input  logic [LEN_W-1:0]       blk_len,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_dout,
  input  logic [DATA_W-1:0]      mem_din,
  output logic                   mem_data_oe,
  output logic                   mem_bus_oe,
  output logic [NBANK-1:0]       mem_cs_n,
  output logic                   mem_we_n,
  output logic                   mem_rd_n,
  input  logic                   bus_req_n,
  input  logic                   start_tx,
  output logic                   tx_ready,
  input  logic                   start_rx,
  input  logic [DATA_W-1:0]      rx_wdata,
  output logic                   rx_take,
  output logic                   rx_ready
);
  localparam int PG_W = ADDR_W - PAGE_LOG2;
  localparam int BK_W = $clog2(NBANK);

  sram_st_t          st;
  logic              wr_q;
  logic [WS_W-1:0]   ws_q;
  logic [BK_W-1:0]   bank_q;
  logic              blk_on, blk_wr;
  logic [LEN_W-1:0]  blk_left;
  logic [ADDR_W-1:0] blk_addr;

  logic              tx_rise, tx_pend, rx_rise, rx_pend;
  logic              tx_go, rx_go, idle_free;
  logic [ADDR_W-1:0] launch_addr;
  logic [BK_W-1:0]   launch_bank;
  logic              tmr_done;

  // Arbitration: bus request, then a running block, then new blocks, then single requests
  assign idle_free   = (st == ST_IDLE) && bus_req_n && !blk_on;
  assign tx_go       = idle_free && tx_pend;
  assign rx_go       = idle_free && !tx_pend && rx_pend;
  assign req_ready   = idle_free && !tx_pend && !rx_pend;
  assign launch_addr = blk_on ? blk_addr : req_addr;

  start_detect u_tx_start (
    .clk(clk), .rst(rst), .start_in(start_tx), .consume(tx_go),
    .rise(tx_rise), .pending(tx_pend)
  );

  start_detect u_rx_start (
    .clk(clk), .rst(rst), .start_in(start_rx), .consume(rx_go),
    .rise(rx_rise), .pending(rx_pend)
  );

  bank_sel #(.NBANK(NBANK), .BND_W(BND_W), .PG_W(PG_W)) u_bank (
    .page(launch_addr[ADDR_W-1 -: PG_W]), .bounds(bank_bound), .bank(launch_bank)
  );

  strobe_timer #(.WS_W(WS_W)) u_tmr (
    .clk(clk), .rst(rst), .load(st == ST_SETUP), .val(ws_q), .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      wr_q        <= 1'b0;
      ws_q        <= '0;
      bank_q      <= '0;
      blk_on      <= 1'b0;
      blk_wr      <= 1'b0;
      blk_left    <= '0;
      blk_addr    <= '0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_data_oe <= 1'b0;
      mem_bus_oe  <= 1'b1;
      mem_cs_n    <= '1;
      mem_we_n    <= 1'b1;
      mem_rd_n    <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      tx_ready    <= 1'b0;
      rx_ready    <= 1'b0;
      rx_take     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rx_take   <= 1'b0;
      if (tx_rise) tx_ready <= 1'b0;
      if (rx_rise) rx_ready <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!bus_req_n) begin
            st         <= ST_YIELD;
            mem_bus_oe <= 1'b0;
          end else if (blk_on || (req_ready && req_valid)) begin
            st          <= ST_SETUP;
            mem_addr    <= launch_addr;
            bank_q      <= launch_bank;
            ws_q        <= ws_cfg;
            wr_q        <= blk_on ? blk_wr : req_write;
            mem_dout    <= blk_on ? rx_wdata : req_wdata;
            mem_data_oe <= blk_on ? blk_wr : req_write;
            rx_take     <= blk_on && blk_wr;
          end else if (tx_go || rx_go) begin
            blk_on   <= 1'b1;
            blk_wr   <= rx_go;
            blk_addr <= blk_base;
            blk_left <= blk_len;
          end
        end
        ST_SETUP: begin
          st       <= ST_STROBE;
          mem_cs_n <= ~(NBANK'(1) << bank_q);
          mem_we_n <= ~wr_q;
          mem_rd_n <= wr_q;
        end
        ST_STROBE: begin
          if (tmr_done) begin
            st       <= ST_HOLD;
            mem_cs_n <= '1;
            mem_we_n <= 1'b1;
            mem_rd_n <= 1'b1;
            if (!wr_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= mem_din;
            end
          end
        end
        ST_HOLD: begin
          st          <= ST_IDLE;
          mem_data_oe <= 1'b0;
          if (blk_on) begin
            if (blk_left == '0) begin
              blk_on <= 1'b0;
              if (blk_wr) rx_ready <= 1'b1;
              else        tx_ready <= 1'b1;
            end else begin
              blk_left <= blk_left - 1'b1;
              blk_addr <= blk_addr + 1'b1;
            end
          end
        end
        ST_YIELD: begin
          if (bus_req_n) begin
            st         <= ST_IDLE;
            mem_bus_oe <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_sram_ctrl_chk.sv
module bank_sram_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int NBANK  = 4,
  parameter int WS_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [WS_W-1:0]   ws_cfg,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NBANK-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_rd_n,
  input logic              mem_data_oe,
  input logic              mem_bus_oe,
  input logic              bus_req_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              tx_ready,
  input logic              rx_ready
);
  logic [WS_W:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)              run_q <= '0;
    else if (~&mem_cs_n)  run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  p_one_cs_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  p_strobe_len_r3: assert property (@(posedge clk) disable iff (rst)
    (&mem_cs_n && !$past(&mem_cs_n)) |-> (run_q == (WS_W+1)'(ws_cfg) + 1'b1));

  p_addr_setup_r4: assert property (@(posedge clk) disable iff (rst)
    (!(&mem_cs_n) && $past(&mem_cs_n)) |-> $stable(mem_addr));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(&mem_cs_n) |-> $stable(mem_addr));

  p_data_drive_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_data_oe);

  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !$past(mem_rd_n));

  p_float_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_bus_oe) |-> (!$past(bus_req_n) && $past(&mem_cs_n)));

  p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_bus_oe |-> (!req_ready && &mem_cs_n));

  p_tx_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> $past(rsp_valid));

  p_rx_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> !$past(mem_we_n, 2));
endmodule

bind bank_sram_ctrl bank_sram_ctrl_chk #(.ADDR_W(ADDR_W), .NBANK(NBANK), .WS_W(WS_W)) u_chk (.*);

// File: tb/bank_sram_ctrl_test.sv
`timescale 1ns/1ps
module bank_sram_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ws_cfg = 3'd0;
  logic [31:0] bank_bound = 32'h2820_1004;
  logic [15:0] blk_base = 16'h0;
  logic [7:0]  blk_len = 8'h0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = 16'h0, req_wdata = 16'h0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dout;
  logic [15:0] mem_din = 16'h0;
  logic        mem_data_oe, mem_bus_oe, mem_we_n, mem_rd_n;
  logic [3:0]  mem_cs_n;
  logic        bus_req_n = 1'b1, start_tx = 1'b0, start_rx = 1'b0;
  logic        tx_ready, rx_take, rx_ready;
  logic [15:0] rx_wdata = 16'hA500;

  bank_sram_ctrl uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int fall_cnt = 0, run = 0, rx_k = 0;
  bit prev_act = 1'b0;
  logic [15:0] prev_addr = 16'h0;
  logic [3:0]  last_cs = 4'hF;
  logic [15:0] ext_mem [int unsigned];
  logic [15:0] rsp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_mem(input logic [15:0] a);
    if (ext_mem.exists(int'(a))) return ext_mem[int'(a)];
    return 16'h0;
  endfunction

  // Bank rule from R2: low 6 bits of each field against address page
  function automatic logic [3:0] exp_cs(input logic [15:0] a, input logic [31:0] b);
    for (int i = 0; i < 4; i++)
      if (a[15:10] < b[i*8 +: 6]) return ~(4'b0001 << i);
    return 4'b0111;
  endfunction

  // Behavioural memory and per-clock reference checks
  always @(negedge clk) begin
    bit act;
    if (rst) begin
      prev_act = 1'b0;
      run = 0;
    end else begin
      act = ~&mem_cs_n;
      if (act && !prev_act) begin
        fall_cnt++;
        last_cs = mem_cs_n;
        check(mem_addr == prev_addr, "R4", "address setup", mem_addr, prev_addr);
        check(mem_cs_n == exp_cs(mem_addr, bank_bound), "R2", "bank select",
              mem_cs_n, exp_cs(mem_addr, bank_bound));
        check($countones(~mem_cs_n) == 1, "R1", "single select", mem_cs_n, 0);
      end
      if (act) run++;
      if (!act && prev_act) begin
        check(run == int'(ws_cfg) + 1, "R3", "strobe cycles", run, int'(ws_cfg) + 1);
        check(mem_addr == prev_addr, "R4", "address hold", mem_addr, prev_addr);
        run = 0;
      end
      if (act && !mem_we_n) begin
        check(mem_data_oe, "R4", "data driven on write", mem_data_oe, 1);
        ext_mem[int'(mem_addr)] = mem_dout;
      end
      mem_din = (act && !mem_rd_n) ? rd_mem(mem_addr) : 16'h0;
      if (rsp_valid) rsp_q.push_back(rsp_rdata);
      if (rx_take) begin
        rx_k++;
        rx_wdata = 16'hA500 + 16'(rx_k);
      end
      prev_act  = act;
      prev_addr = mem_addr;
    end
  end

  task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [15:0] exp, input string req);
    int n;
    rsp_q.delete();
    do_req(1'b0, a, 16'h0);
    n = 0;
    while (rsp_q.size() == 0 && n < 40) begin @(negedge clk); n++; end
    if (rsp_q.size() == 0) check(1'b0, req, "no read response", 0, exp);
    else check(rsp_q[0] == exp, req, "read data", rsp_q[0], exp);
    rsp_q.delete();
  endtask

  task automatic wr_done(input logic [15:0] a, input logic [15:0] d);
    do_req(1'b1, a, d);
    repeat (14) @(negedge clk);
  endtask

  task automatic wait_flag(ref logic f, input string req);
    int n = 0;
    while (!f && n < 400) begin @(negedge clk); n++; end
    check(f == 1'b1, req, "ready flag rose", f, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(mem_cs_n == 4'hF, "R9", "selects idle", mem_cs_n, 4'hF);
    check(mem_we_n && mem_rd_n, "R9", "strobes idle", {mem_we_n, mem_rd_n}, 2'b11);
    check(mem_bus_oe && !mem_data_oe, "R9", "bus drive", {mem_bus_oe, mem_data_oe}, 2'b10);
    check(!tx_ready && !rx_ready && !rsp_valid, "R9", "flags",
          {tx_ready, rx_ready, rsp_valid}, 0);
    check(req_ready, "R9", "ready after reset", req_ready, 1);

    // R2 R3 R5 single accesses across banks and wait states
    wr_done(16'h0100, 16'h1111);
    rd_expect(16'h0100, 16'h1111, "R5");
    check(last_cs == 4'b1110, "R2", "page 0 to bank 0", last_cs, 4'b1110);
    wr_done(16'h3000, 16'h2222);
    rd_expect(16'h3000, 16'h2222, "R5");
    check(last_cs == 4'b1101, "R2", "page 0x0C to bank 1", last_cs, 4'b1101);
    ws_cfg = 3'd3;
    wr_done(16'h5000, 16'h3333);
    rd_expect(16'h5000, 16'h3333, "R3");
    check(last_cs == 4'b1011, "R2", "page 0x14 to bank 2", last_cs, 4'b1011);
    ws_cfg = 3'd7;
    wr_done(16'hFC00, 16'h4444);
    rd_expect(16'hFC00, 16'h4444, "R3");
    check(last_cs == 4'b0111, "R2", "beyond boundaries to bank 3", last_cs, 4'b0111);
    // R2 boundary upper bits ignored: 0xC0 has low bits 0
    bank_bound = 32'h28C0_1004;
    ws_cfg = 3'd1;
    rd_expect(16'h5000, 16'h3333, "R2");
    check(last_cs == 4'b0111, "R2", "upper boundary bits ignored", last_cs, 4'b0111);
    bank_bound = 32'h2820_1004;

    // R6 bus surrender during a write, pending read held off
    ws_cfg = 3'd3;
    begin
      int n, f0;
      do_req(1'b1, 16'h3004, 16'hBEEF);
      bus_req_n = 1'b0;
      n = 0;
      while (mem_bus_oe && n < 30) begin @(negedge clk); n++; end
      check(!mem_bus_oe, "R6", "bus floated", mem_bus_oe, 0);
      check(rd_mem(16'h3004) == 16'hBEEF, "R6", "access completed first",
            rd_mem(16'h3004), 16'hBEEF);
      f0 = fall_cnt;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3004;
      repeat (8) @(negedge clk);
      check(!req_ready, "R6", "request held off", req_ready, 0);
      check(fall_cnt == f0, "R6", "no access while surrendered", fall_cnt, f0);
      check(!mem_bus_oe, "R6", "still floated", mem_bus_oe, 0);
      rsp_q.delete();
      bus_req_n = 1'b1;
      @(negedge clk);
      check(mem_bus_oe, "R6", "re-driven after release", mem_bus_oe, 1);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (rsp_q.size() == 0 && n < 40) begin @(negedge clk); n++; end
      check(rsp_q.size() == 1 && rsp_q[0] == 16'hBEEF, "R6", "held read served",
            rsp_q.size() > 0 ? rsp_q[0] : 16'h0, 16'hBEEF);
      rsp_q.delete();
    end

    // R7 block read across the page 3 / page 4 boundary
    ws_cfg = 3'd2;
    for (int i = 0; i < 6; i++) ext_mem[int'(16'h0FFE + 16'(i))] = 16'h7000 + 16'(i);
    blk_base = 16'h0FFE; blk_len = 8'd5;
    rsp_q.delete();
    start_tx = 1'b1; repeat (2) @(negedge clk); start_tx = 1'b0;
    wait_flag(tx_ready, "R7");
    check(rsp_q.size() == 6, "R7", "word count", rsp_q.size(), 6);
    for (int i = 0; i < 6; i++)
      if (i < rsp_q.size())
        check(rsp_q[i] == 16'h7000 + 16'(i), "R7", "block word", rsp_q[i], 16'h7000 + 16'(i));
    rsp_q.delete();
    start_tx = 1'b1; repeat (2) @(negedge clk); start_tx = 1'b0;
    check(!tx_ready, "R7", "ready cleared by new start", tx_ready, 0);
    wait_flag(tx_ready, "R7");
    rsp_q.delete();

    // R8 block write wrapping past the top of memory
    ws_cfg = 3'd0;
    blk_base = 16'hFFFE; blk_len = 8'd3;
    rx_k = 0; rx_wdata = 16'hA500;
    start_rx = 1'b1; repeat (2) @(negedge clk); start_rx = 1'b0;
    wait_flag(rx_ready, "R8");
    check(rx_k == 4, "R8", "words taken", rx_k, 4);
    check(rd_mem(16'hFFFE) == 16'hA500, "R8", "word 0", rd_mem(16'hFFFE), 16'hA500);
    check(rd_mem(16'hFFFF) == 16'hA501, "R8", "word 1", rd_mem(16'hFFFF), 16'hA501);
    check(rd_mem(16'h0000) == 16'hA502, "R8", "word 2 wrapped", rd_mem(16'h0000), 16'hA502);
    check(rd_mem(16'h0001) == 16'hA503, "R8", "word 3", rd_mem(16'h0001), 16'hA503);
    start_rx = 1'b1; repeat (2) @(negedge clk); start_rx = 1'b0;
    check(!rx_ready, "R8", "ready cleared by new start", rx_ready, 0);
    wait_flag(rx_ready, "R8");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule